// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical frame number by walking a two-level page table that lives in memory. A requester hands it a virtual address and an access kind; the walker reads one 32-bit table entry per level over a simple valid/ready memory port, decodes the entry, and either follows a pointer to the next table or stops at a leaf. It finishes with a single-cycle result that carries the frame number, the flag byte of the leaf and the page-size shift, or with a fault and a cause code.

The root table and the translation mode come from an address-translation control word supplied on an input. With the mode bit clear the walker performs no memory access and returns the virtual page number as the frame. It accepts a single request at a time. A caching structure for finished translations and the memory itself sit outside this block.

Top module: `sv32_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_req_valid` and `done_valid` are 0.
- R2: From the cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge) until and including the cycle in which `done_valid` is high, `req_ready` is 0; `done_valid` is high for exactly one cycle per accepted request.
- R3: When `satp[31]` is 0 at acceptance, no table entry is read and `done_valid` rises in the very next cycle with frame = vaddr[31:12], shift 12, flags 0, no fault.
- R4: When `satp[31]` is 1, the first entry is read at `satp[21:0]`*4096 + vaddr[31:22]*4 and, after a pointer, the second at entry[31:10]*4096 + vaddr[21:12]*4; `mem_req_addr` holds steady while `mem_req_valid` is high and `mem_req_ready` is low.
- R5: An entry with V (bit 0) clear, or with R (bit 1) clear and W (bit 2) set, ends the walk with cause 1 (invalid).
- R6: A valid entry with R, W and X (bit 3) all clear is a pointer; at the top level the walk descends, at the second level it ends with cause 2 (no leaf).
- R7: A leaf found at the top level is a 4 MiB page: frame = entry[31:20], shift 22; if entry[19:10] is nonzero it ends with cause 4 (misaligned).
- R8: A leaf found at the second level is a 4 KiB page: frame = entry[31:10], shift 12; for every successful leaf the returned flags equal entry[7:0].
- R9: Access kind codes are 0 = load (needs R), 1 = store (needs W), 2 = fetch (needs R and X), 3 = reserved (always refused); a refused leaf ends with cause 3, and this check takes priority over the misalignment check of R7.
- R10: A faulting result has `done_fault` = 1 with frame, flags and shift all 0; a successful result has `done_fault` = 0 and cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| satp | input | 32 | Translation control: bit 31 mode, bits 21:0 root table page number |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 34 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry contents |
| done_valid | output | 1 | Result present, one cycle |
| done_frame | output | 22 | Physical frame number |
| done_flags | output | 8 | Flag byte of the leaf entry |
| done_shift | output | 5 | Page-size shift (12 or 22) |
| done_fault | output | 1 | Walk ended in a page fault |
| done_cause | output | 3 | Fault cause: 0 none, 1 invalid, 2 no leaf, 3 permission, 4 misaligned |

## Verification
The result pulse of one walk and the arrival of the next request coincide: the bench raises `req_valid` for the following translation in the same cycle that `done_valid` is high, so the walker must refuse it in that cycle and take it in the next. A per-cycle model tracks when the walker should be busy and compares `req_ready` and the single-cycle result pulse against it on every clock. A second overlap, the memory answering in the first cycle the walker can listen while the port also stalls requests, is provoked with zero-latency responses mixed with a throttled `mem_req_ready`, and judged by the exact sequence of entry addresses read.

// File: rtl/walk_pkg.sv
package walk_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        C_NONE     = 3'd0,
        C_INVALID  = 3'd1,
        C_NOLEAF   = 3'd2,
        C_PERM     = 3'd3,
        C_MISALIGN = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } wst_e;

    localparam int FLAG_V = 0;
    localparam int FLAG_R = 1;
    localparam int FLAG_W = 2;
    localparam int FLAG_X = 3;
    localparam int FLAG_BYTE = 8;
endpackage

// File: rtl/walk_access_check.sv
module walk_access_check
    import walk_pkg::*;
(
    input  acc_e kind,
    input  logic can_r,
    input  logic can_w,
    input  logic can_x,
    output logic allowed
);
    always_comb begin
        case (kind)
            ACC_LOAD:  allowed = can_r;
            ACC_STORE: allowed = can_w;
            ACC_FETCH: allowed = can_r & can_x;
            default:   allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/walk_pte_eval.sv
module walk_pte_eval
    import walk_pkg::*;
#(
    parameter int PTE_W    = 32,
    parameter int PPN_W    = 22,
    parameter int VPN_W    = 10,
    parameter int SHIFT_W  = 5,
    parameter int PAGE_SH  = 12,
    parameter int SUPER_SH = 22
) (
    input  logic [PTE_W-1:0]     pte,
    input  logic                 top_level,
    input  acc_e                 kind,
    output logic                 descend,
    output logic [PPN_W-1:0]     next_tbl,
    output cause_e               cause,
    output logic [PPN_W-1:0]     frame,
    output logic [FLAG_BYTE-1:0] flags,
    output logic [SHIFT_W-1:0]   shift
);
    localparam int PPN_LSB = PTE_W - PPN_W;
    localparam int HI_W    = PPN_W - VPN_W;

    logic fv, fr, fw, fx, perm_ok, is_ptr, bad;
    logic [VPN_W-1:0] ppn_lo;
    logic [HI_W-1:0]  ppn_hi;
    logic [PPN_LSB-FLAG_BYTE-1:0] unused_rsw;

    assign fv = pte[FLAG_V];
    assign fr = pte[FLAG_R];
    assign fw = pte[FLAG_W];
    assign fx = pte[FLAG_X];
    assign ppn_lo = pte[PPN_LSB +: VPN_W];
    assign ppn_hi = pte[PTE_W-1 -: HI_W];
    assign unused_rsw = pte[PPN_LSB-1:FLAG_BYTE];
    assign bad    = !fv || (!fr && fw);
    assign is_ptr = !fr && !fw && !fx;
    assign next_tbl = pte[PTE_W-1:PPN_LSB];

    walk_access_check u_perm (
        .kind    (kind),
        .can_r   (fr),
        .can_w   (fw),
        .can_x   (fx),
        .allowed (perm_ok)
    );

    always_comb begin
        descend = 1'b0;
        cause   = C_NONE;
        frame   = '0;
        flags   = '0;
        shift   = '0;
        if (bad) begin
            cause = C_INVALID;
        end else if (is_ptr) begin
            if (top_level) descend = 1'b1;
            else           cause   = C_NOLEAF;
        end else if (!perm_ok) begin
            cause = C_PERM;
        end else if (top_level && (ppn_lo != '0)) begin
            cause = C_MISALIGN;
        end else begin
            flags = pte[FLAG_BYTE-1:0];
            if (top_level) begin
                frame = {{VPN_W{1'b0}}, ppn_hi};
                shift = SHIFT_W'(SUPER_SH);
            end else begin
                frame = pte[PTE_W-1:PPN_LSB];
                shift = SHIFT_W'(PAGE_SH);
            end
        end
    end
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
    import walk_pkg::*;
#(
    parameter int PPN_W     = 22,
    parameter int VPN_W     = 10,
    parameter int PAGE_SH   = 12,
    parameter int PTE_BYTES = 4,
    parameter int SHIFT_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [31:0]              satp,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [31:0]              req_vaddr,
    input  logic [1:0]               req_kind,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [PPN_W+PAGE_SH-1:0] mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [8*PTE_BYTES-1:0]   mem_rsp_data,
    output logic                     done_valid,
    output logic [PPN_W-1:0]         done_frame,
    output logic [7:0]               done_flags,
    output logic [SHIFT_W-1:0]       done_shift,
    output logic                     done_fault,
    output logic [2:0]               done_cause
);
    localparam int PTE_W    = 8 * PTE_BYTES;
    localparam int IDX_SH   = $clog2(PTE_BYTES);
    localparam int VA_W     = 2 * VPN_W + PAGE_SH;
    localparam int SUPER_SH = VPN_W + PAGE_SH;
    localparam int MODE_BIT = 31;

    typedef struct packed {
        wst_e                 st;
        logic                 lvl;
        logic [PPN_W-1:0]     tbl;
        logic [2*VPN_W-1:0]   vpn;
        acc_e                 kind;
        logic [PPN_W-1:0]     frame;
        logic [FLAG_BYTE-1:0] flags;
        logic [SHIFT_W-1:0]   shift;
        cause_e               cause;
    } walk_t;

    walk_t walk_d, walk_q;

    logic                 ev_descend;
    logic [PPN_W-1:0]     ev_next, ev_frame;
    cause_e               ev_cause;
    logic [FLAG_BYTE-1:0] ev_flags;
    logic [SHIFT_W-1:0]   ev_shift;
    logic [VPN_W-1:0]     vpn_sel;
    logic                 unused_inputs;

    assign unused_inputs = ^{satp[30:PPN_W], req_vaddr[PAGE_SH-1:0]};

    walk_pte_eval #(
        .PTE_W    (PTE_W),
        .PPN_W    (PPN_W),
        .VPN_W    (VPN_W),
        .SHIFT_W  (SHIFT_W),
        .PAGE_SH  (PAGE_SH),
        .SUPER_SH (SUPER_SH)
    ) u_eval (
        .pte       (mem_rsp_data),
        .top_level (walk_q.lvl),
        .kind      (walk_q.kind),
        .descend   (ev_descend),
        .next_tbl  (ev_next),
        .cause     (ev_cause),
        .frame     (ev_frame),
        .flags     (ev_flags),
        .shift     (ev_shift)
    );

    always_comb begin
        walk_d = walk_q;
        case (walk_q.st)
            S_IDLE: if (req_valid) begin
                walk_d.vpn  = req_vaddr[VA_W-1:PAGE_SH];
                walk_d.kind = acc_e'(req_kind);
                if (satp[MODE_BIT]) begin
                    walk_d.st  = S_ISSUE;
                    walk_d.lvl = 1'b1;
                    walk_d.tbl = satp[PPN_W-1:0];
                end else begin
                    walk_d.st    = S_DONE;
                    walk_d.frame = PPN_W'(req_vaddr[VA_W-1:PAGE_SH]);
                    walk_d.flags = '0;
                    walk_d.shift = SHIFT_W'(PAGE_SH);
                    walk_d.cause = C_NONE;
                end
            end
            S_ISSUE: if (mem_req_ready) walk_d.st = S_WAIT;
            S_WAIT: if (mem_rsp_valid) begin
                if (ev_descend) begin
                    walk_d.st  = S_ISSUE;
                    walk_d.lvl = 1'b0;
                    walk_d.tbl = ev_next;
                end else begin
                    walk_d.st    = S_DONE;
                    walk_d.frame = ev_frame;
                    walk_d.flags = ev_flags;
                    walk_d.shift = ev_shift;
                    walk_d.cause = ev_cause;
                end
            end
            default: walk_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign vpn_sel       = walk_q.lvl ? walk_q.vpn[2*VPN_W-1:VPN_W] : walk_q.vpn[VPN_W-1:0];
    assign req_ready     = (walk_q.st == S_IDLE);
    assign mem_req_valid = (walk_q.st == S_ISSUE);
    assign mem_req_addr  = {walk_q.tbl, vpn_sel, {IDX_SH{1'b0}}};
    assign done_valid    = (walk_q.st == S_DONE);
    assign done_frame    = walk_q.frame;
    assign done_flags    = walk_q.flags;
    assign done_shift    = walk_q.shift;
    assign done_cause    = walk_q.cause;
    assign done_fault    = (walk_q.cause != C_NONE);

    p_busy_while_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !req_ready);
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
    p_bare_next_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !satp[MODE_BIT]) |=>
        (done_valid && !done_fault && done_shift == SHIFT_W'(PAGE_SH)));
    p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    p_shift_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault) |->
        (done_shift == SHIFT_W'(PAGE_SH) || done_shift == SHIFT_W'(SUPER_SH)));
    p_fault_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |-> (done_frame == '0 && done_flags == '0 && done_shift == '0));
endmodule

// File: tb/test_sv32_walker.sv
module test_sv32_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] satp = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [21:0] done_frame;
    logic [7:0]  done_flags;
    logic [4:0]  done_shift;
    logic        done_fault;
    logic [2:0]  done_cause;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sv32_walker i_sv32_walker (
        .clk(clk), .rst_n(rst_n), .satp(satp),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done_valid(done_valid),
        .done_frame(done_frame), .done_flags(done_flags),
        .done_shift(done_shift), .done_fault(done_fault),
        .done_cause(done_cause)
    );

    // page table memory of the bench
    logic [31:0] pmem [longint];
    longint got_addrs[$];
    longint exp_addrs[$];
    int  lat_cfg = 0;
    bit  slow_cfg = 0;

    longint   exp_frame;
    int       exp_flags, exp_shift, exp_cause;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input longint a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    // behavioural reference translation
    function automatic void ref_walk(input logic [31:0] va, input int kind, input logic [31:0] sp);
        longint tbl;
        int lvl;
        bit fin;
        logic [31:0] e;
        longint a;
        bit v, r, w, x, ok;
        exp_addrs.delete();
        exp_frame = 0; exp_flags = 0; exp_shift = 0; exp_cause = 0;
        if (!sp[31]) begin
            exp_frame = longint'(va[31:12]);
            exp_shift = 12;
            return;
        end
        tbl = longint'(sp[21:0]);
        lvl = 1;
        fin = 0;
        while (!fin) begin
            a = tbl * 4096 + (lvl == 1 ? longint'(va[31:22]) : longint'(va[21:12])) * 4;
            exp_addrs.push_back(a);
            e = rd(a);
            v = e[0]; r = e[1]; w = e[2]; x = e[3];
            fin = 1;
            if (!v || (!r && w)) exp_cause = 1;
            else if (!r && !w && !x) begin
                if (lvl == 0) exp_cause = 2;
                else begin tbl = longint'(e[31:10]); lvl = 0; fin = 0; end
            end else begin
                case (kind)
                    0: ok = r;
                    1: ok = w;
                    2: ok = r && x;
                    default: ok = 0;
                endcase
                if (!ok) exp_cause = 3;
                else if (lvl == 1 && e[19:10] != 0) exp_cause = 4;
                else begin
                    exp_flags = int'(e[7:0]);
                    if (lvl == 1) begin exp_frame = longint'(e[31:20]); exp_shift = 22; end
                    else begin exp_frame = longint'(e[31:10]); exp_shift = 12; end
                end
            end
        end
    endfunction

    // memory responder
    initial begin
        bit pv = 0, pr = 0, pending = 0;
        longint pa = 0;
        int cnt = 0, tick = 0;
        logic [31:0] pdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pv && pr) begin
                got_addrs.push_back(pa);
                pdata = rd(pa);
                cnt = lat_cfg;
                pending = 1;
            end
            if (pending) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = pdata;
                    pending = 0;
                end else cnt--;
            end
            mem_req_ready = slow_cfg ? (tick % 3 == 2) : 1'b1;
            tick++;
            pv = mem_req_valid;
            pr = mem_req_ready;
            pa = longint'(mem_req_addr);
        end
    end

    // per-cycle model of busy state and result pulse (R2)
    initial begin
        bit busy = 0, prev_hs = 0, prev_done = 0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (prev_done) busy = 0;
                if (prev_hs) busy = 1;
                chk(req_ready == !busy, "R2", "req_ready vs busy model", req_ready, !busy);
                if (prev_done)
                    chk(!done_valid, "R2", "done pulse longer than one cycle", done_valid, 0);
                prev_hs = req_valid && req_ready;
                prev_done = done_valid;
            end
        end
    end

    task automatic run_case(input string tag, input logic [31:0] va, input int kind,
                            input logic [31:0] sp, input int lat, input bit slow);
        int cyc;
        ref_walk(va, kind, sp);
        got_addrs.delete();
        lat_cfg = lat;
        slow_cfg = slow;
        satp = sp;
        req_vaddr = va;
        req_kind = 2'(kind);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done_valid && cyc < 200) begin @(negedge clk); cyc++; end
        chk(done_valid, tag, "result arrived", done_valid, 1);
        if (!sp[31]) chk(cyc == 1, "R3", "bare result latency", cyc, 1);
        chk(longint'(done_frame) == exp_frame, tag, "frame", done_frame, exp_frame);
        chk(int'(done_flags) == exp_flags, tag, "flags", done_flags, exp_flags);
        chk(int'(done_shift) == exp_shift, tag, "shift", done_shift, exp_shift);
        chk(int'(done_cause) == exp_cause, tag, "cause", done_cause, exp_cause);
        chk(done_fault == (exp_cause != 0), "R10", "fault flag", done_fault, exp_cause != 0);
        chk(got_addrs.size() == exp_addrs.size(), "R4", "entry reads", got_addrs.size(), exp_addrs.size());
        foreach (exp_addrs[i])
            if (i < got_addrs.size())
                chk(got_addrs[i] == exp_addrs[i], "R4", "entry address", got_addrs[i], exp_addrs[i]);
    endtask

    function automatic longint root_a(input int i);
        return 64'h100000 + i * 4;
    endfunction
    function automatic longint t2_a(input int i);
        return 64'h200000 + i * 4;
    endfunction
    function automatic logic [31:0] mkva(input int hi, input int lo, input int off);
        return {10'(hi), 10'(lo), 12'(off)};
    endfunction

    initial begin
        logic [31:0] sv;
        sv = 32'h8000_0100;
        pmem[root_a(1)] = {22'h200, 2'b00, 8'h01};
        pmem[t2_a(2)]   = {22'h12345, 2'b11, 8'hCF};
        pmem[t2_a(3)]   = {22'h0ABCD, 2'b00, 8'h03};
        pmem[t2_a(5)]   = {22'h00777, 2'b00, 8'h09};
        pmem[t2_a(4)]   = {22'h300, 2'b00, 8'h01};
        pmem[root_a(5)] = {12'hABC, 10'h0, 2'b00, 8'h0F};
        pmem[root_a(6)] = {12'h123, 10'h5, 2'b00, 8'h0F};
        pmem[root_a(7)] = {12'h123, 10'h5, 2'b00, 8'h03};
        pmem[root_a(8)] = {22'h00400, 2'b00, 8'h05};
        pmem[root_a(9)] = {12'h055, 10'h0, 2'b00, 8'h0B};

        repeat (3) @(negedge clk);
        chk(req_ready && !mem_req_valid && !done_valid, "R1", "state in reset",
            {req_ready, mem_req_valid, done_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", mem_req_valid, 0);
        chk(done_valid == 1'b0, "R1", "done_valid after reset", done_valid, 0);

        run_case("R3", 32'hDEAD_B123, 0, 32'h0000_0100, 0, 0);
        run_case("R8", mkva(1, 2, 12'h345), 0, sv, 0, 0);
        run_case("R8", mkva(1, 2, 12'h010), 1, sv, 2, 1);
        run_case("R9", mkva(1, 2, 12'h020), 2, sv, 1, 0);
        run_case("R9", mkva(1, 3, 0), 1, sv, 0, 1);
        run_case("R8", mkva(1, 3, 0), 0, sv, 3, 0);
        run_case("R9", mkva(1, 3, 0), 2, sv, 0, 0);
        run_case("R9", mkva(1, 5, 0), 2, sv, 0, 1);
        run_case("R9", mkva(1, 5, 0), 0, sv, 1, 0);
        run_case("R9", mkva(1, 2, 0), 3, sv, 0, 0);
        run_case("R7", mkva(5, 7, 12'hFFF), 0, sv, 0, 0);
        run_case("R7", mkva(9, 1, 0), 2, sv, 2, 1);
        run_case("R7", mkva(6, 0, 0), 0, sv, 0, 1);
        run_case("R9", mkva(7, 0, 0), 1, sv, 0, 0);
        run_case("R5", mkva(0, 0, 0), 0, sv, 0, 0);
        run_case("R5", mkva(8, 0, 0), 0, sv, 1, 1);
        run_case("R5", mkva(1, 9, 0), 0, sv, 0, 0);
        run_case("R6", mkva(1, 4, 0), 0, sv, 2, 0);
        run_case("R3", 32'h0000_0FFF, 1, 32'h7FFF_FFFF, 0, 0);
        run_case("R8", mkva(1, 2, 0), 0, sv, 0, 1);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule